// File: doc/BRIEF.md
# Nanosecond Time Base with One-Shot Alarm

This peripheral keeps a free-running time count in nanoseconds and raises one programmable alarm. The count is twice the bus data width (64 bits at the default 32-bit bus) and is compared as a signed number. It advances by a fixed number of nanoseconds on every clock. Software reads the count as two bus words. A read of the lower word also copies the upper word of the same instant into a holding register. A later read of the upper word returns that held copy, so the two halves always come from one snapshot.

The alarm is loaded in two steps. The upper half is written first and is only staged. The write of the lower half completes the compare value and arms the alarm. When an armed alarm is reached, it disarms itself and sets an interrupt-pending flag. It does not rearm. The interrupt output is the pending flag gated by an enable bit. The pending flag is removed only by an explicit acknowledge write.

Top module: `nsalarm_timer`

## Requirements
- R1: After reset the count is zero. On every clock without reset it grows by STEP_NS. A read at word index 0 (byte offset 0x00) returns the lower data word of the live count.
- R2: A read at word index 0 copies the upper word of the count into a holding register. A read at word index 1 (0x04) returns that held value, not the live upper word.
- R3: A write at word index 3 (0x0c) only stages the upper alarm word. It does not arm the alarm and does not change the armed status.
- R4: A write at word index 2 (0x08) loads the alarm as {staged upper word, written lower word} and arms it. A read at word index 6 (0x18) returns 1 in bit 0 while the alarm is armed, otherwise 0.
- R5: An armed alarm fires on the first clock edge at which the signed count is greater than or equal to the alarm value. Firing clears the armed status and sets the pending flag. A fired alarm stays disarmed until the lower alarm word is written again.
- R6: An alarm value already reached when it is armed, including a negative value (most significant bit set), fires on the clock edge right after the arming edge.
- R7: A write at word index 5 (0x14) disarms the alarm. A disarmed alarm never sets the pending flag.
- R8: Bit 0 of the register at word index 4 (0x10) is the interrupt enable, and the register reads back that bit. The irq output equals pending AND enable. Changing the enable does not clear the pending flag. Only a write at word index 7 (0x1c) clears it.
- R9: Reads at word indices 2, 3, 5 and 7 return zero. Writes at word indices 0, 1 and 6 change no state.
- R10: Synchronous reset clears the count, the holding register, the staged and loaded alarm, the armed status, the pending flag and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the word, higher bits must be zero |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| irq | output | 1 | Alarm interrupt request |

## Verification
The bench uses a 32-bit bus, signed comparison, and a step of 0x0400_0003 nanoseconds per clock. With that step the upper count word changes about every 64 cycles. This puts carries into the upper half, stale-versus-live holding-register reads, and alarms that straddle a word boundary within a short run. Random alarm targets are placed around the live count, some in the past and some negative. This exercises the immediate-fire path, arm and disarm writes that land on the firing edge, and acknowledge writes that collide with a new firing.

// File: rtl/nsat_pkg.sv
package nsat_pkg;

   // word index = byte address bits [4:2]
   typedef enum logic [2:0] {
      WI_TIME_LO  = 3'd0,
      WI_TIME_HI  = 3'd1,
      WI_ALM_LO   = 3'd2,
      WI_ALM_HI   = 3'd3,
      WI_IRQ_EN   = 3'd4,
      WI_DISARM   = 3'd5,
      WI_ARMED    = 3'd6,
      WI_ACK      = 3'd7
   } word_idx_e;

   localparam int WORD_LSB = 2;
   localparam int MAP_BITS = 5;

endpackage

// File: rtl/nsat_counter.sv
module nsat_counter #(
   parameter int DATA_W  = 32,
   parameter int STEP_NS = 1,
   localparam int CNT_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] held_hi
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         held_hi <= '0;
      end else begin
         cnt <= cnt + STEP;
         if (capture) held_hi <= cnt[CNT_W-1:DATA_W];
      end
   end

endmodule

// File: rtl/nsat_alarm.sv
module nsat_alarm #(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1,
   localparam int CNT_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] wdata,
   input  logic              stage_hi,
   input  logic              load_arm,
   input  logic              disarm,
   input  logic              ack,
   output logic              armed,
   output logic              pend
);

   logic [DATA_W-1:0] hi_stage;
   logic [CNT_W-1:0]  target;
   logic              reached;
   logic              fire;

   generate
      if (SIGNED_CMP) begin : g_scmp
         assign reached = $signed(cnt) >= $signed(target);
      end else begin : g_ucmp
         assign reached = cnt >= target;
      end
   endgenerate

   // a new arm or a disarm in the same cycle overrides the firing
   assign fire = armed && reached && !load_arm && !disarm;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_stage <= '0;
         target   <= '0;
         armed    <= 1'b0;
         pend     <= 1'b0;
      end else begin
         if (stage_hi) hi_stage <= wdata;
         if (load_arm) begin
            target <= {hi_stage, wdata};
            armed  <= 1'b1;
         end else if (disarm || fire) begin
            armed  <= 1'b0;
         end
         if (fire)     pend <= 1'b1;
         else if (ack) pend <= 1'b0;
      end
   end

endmodule

// File: rtl/nsalarm_timer.sv
module nsalarm_timer #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 5,
   parameter int STEP_NS    = 1,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import nsat_pkg::*;

   localparam int CNT_W = 2 * DATA_W;

   generate
      if (DATA_W < 8)          begin : g_bad_dw   $error("DATA_W below 8"); end
      if (ADDR_W < MAP_BITS)   begin : g_bad_aw   $error("ADDR_W too narrow for map"); end
      if (STEP_NS < 1)         begin : g_bad_step $error("STEP_NS must be positive"); end
   endgenerate

   logic [2:0]       widx;
   logic             hit;
   logic             rd_go, wr_go;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] held_hi;
   logic             armed, pend, en;
   logic             wr_lo, wr_hi, wr_disarm, wr_ack;

   assign widx  = bus_addr[WORD_LSB +: 3];
   generate
      if (ADDR_W > MAP_BITS) begin : g_upper
         assign hit = (bus_addr[ADDR_W-1:MAP_BITS] == '0);
      end else begin : g_noupper
         assign hit = 1'b1;
      end
   endgenerate

   assign rd_go     = bus_sel && !bus_wr && hit;
   assign wr_go     = bus_sel &&  bus_wr && hit;
   assign wr_lo     = wr_go && (widx == WI_ALM_LO);
   assign wr_hi     = wr_go && (widx == WI_ALM_HI);
   assign wr_disarm = wr_go && (widx == WI_DISARM);
   assign wr_ack    = wr_go && (widx == WI_ACK);

   nsat_counter #(.DATA_W(DATA_W), .STEP_NS(STEP_NS)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .capture (rd_go && (widx == WI_TIME_LO)),
      .cnt     (cnt),
      .held_hi (held_hi)
   );

   nsat_alarm #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_alm (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .wdata    (bus_wdata),
      .stage_hi (wr_hi),
      .load_arm (wr_lo),
      .disarm   (wr_disarm),
      .ack      (wr_ack),
      .armed    (armed),
      .pend     (pend)
   );

   always_ff @(posedge clk) begin
      if (rst)                             en <= 1'b0;
      else if (wr_go && widx == WI_IRQ_EN) en <= bus_wdata[0];
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_go) begin
         case (widx)
            WI_TIME_LO: bus_rdata = cnt[DATA_W-1:0];
            WI_TIME_HI: bus_rdata = held_hi;
            WI_IRQ_EN:  bus_rdata = {{(DATA_W-1){1'b0}}, en};
            WI_ARMED:   bus_rdata = {{(DATA_W-1){1'b0}}, armed};
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign irq = pend && en;

endmodule

// File: rtl/nsalarm_timer_chk.sv
module nsalarm_timer_chk #(
   parameter int DATA_W  = 32,
   parameter int STEP_NS = 1,
   localparam int CNT_W  = 2 * DATA_W
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] cnt,
   input logic             armed,
   input logic             pend,
   input logic             en,
   input logic             irq,
   input logic             wr_lo,
   input logic             wr_hi,
   input logic             wr_disarm,
   input logic             wr_ack
);

   logic seen;
   always_ff @(posedge clk) seen <= !rst;

   p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
      seen |-> cnt == $past(cnt) + CNT_W'(STEP_NS));

   p_stage_noarm_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !wr_lo && !armed) |=> !armed);

   p_load_arms_r4: assert property (@(posedge clk) disable iff (rst)
      wr_lo |=> armed);

   p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
      (seen && $fell(armed) && !$past(wr_disarm)) |-> pend);

   p_disarm_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_disarm && !wr_lo) |=> !armed);

   p_pend_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (pend && !wr_ack) |=> pend);

   p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
      irq |-> (en && pend));

endmodule

bind nsalarm_timer nsalarm_timer_chk #(.DATA_W(DATA_W), .STEP_NS(STEP_NS)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .cnt       (cnt),
   .armed     (armed),
   .pend      (pend),
   .en        (en),
   .irq       (irq),
   .wr_lo     (wr_lo),
   .wr_hi     (wr_hi),
   .wr_disarm (wr_disarm),
   .wr_ack    (wr_ack)
);

// File: tb/nsalarm_timer_tb_top.sv
`timescale 1ns/1ps
module nsalarm_timer_tb_top;

   localparam int DW   = 32;
   localparam int AW   = 5;
   localparam int STEP = 32'h0400_0003;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr  = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;

   always #5 clk = ~clk;

   nsalarm_timer #(.DATA_W(DW), .ADDR_W(AW), .STEP_NS(STEP), .SIGNED_CMP(1'b1)) dut_i (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // ---------------- reference model built from the requirements
   logic [63:0] m_cnt, m_alarm;
   logic [31:0] m_hold, m_stage;
   logic        m_armed, m_pend, m_en;

   always @(posedge clk) begin
      logic       w, fire;
      logic [2:0] a;
      if (rst) begin
         m_cnt <= '0; m_alarm <= '0; m_hold <= '0; m_stage <= '0;
         m_armed <= 1'b0; m_pend <= 1'b0; m_en <= 1'b0;
      end else begin
         a    = bus_addr[4:2];
         w    = bus_sel && bus_wr;
         fire = m_armed && ($signed(m_cnt) >= $signed(m_alarm))
                && !(w && a == 3'd2) && !(w && a == 3'd5);
         m_cnt <= m_cnt + 64'(STEP);
         if (bus_sel && !bus_wr && a == 3'd0) m_hold <= m_cnt[63:32];
         if (w && a == 3'd3) m_stage <= bus_wdata;
         if (w && a == 3'd2) begin m_alarm <= {m_stage, bus_wdata}; m_armed <= 1'b1; end
         else if ((w && a == 3'd5) || fire) m_armed <= 1'b0;
         if (fire) m_pend <= 1'b1;
         else if (w && a == 3'd7) m_pend <= 1'b0;
         if (w && a == 3'd4) m_en <= bus_wdata[0];
      end
   end

   function automatic logic [31:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0:    return m_cnt[31:0];
         3'd1:    return m_hold;
         3'd4:    return {31'd0, m_en};
         3'd6:    return {31'd0, m_armed};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0:    return "R1";
         3'd1:    return "R2";
         3'd4:    return "R8";
         3'd6:    return "R4";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && !rst) begin
         #2;
         check("R8 irq", {63'd0, irq}, {63'd0, m_pend & m_en});
      end
   end

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {a, 2'b00};
      #1 d = bus_rdata;
      check(tag_of(a), {32'd0, d}, {32'd0, exp_rd(a)});
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_wrt(input logic [2:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {a, 2'b00}; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic arm_at(input logic [63:0] t);
      bus_wrt(3'd3, t[63:32]);
      bus_wrt(3'd2, t[31:0]);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, lo_snap, hi_snap;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      mon_on = 1'b1;

      // R10: reset state
      #1;
      check("R10 irq", {63'd0, irq}, 64'd0);
      bus_rd(3'd6, d); check("R10 armed", {32'd0, d}, 64'd0);
      bus_rd(3'd1, d); check("R10 hold", {32'd0, d}, 64'd0);
      bus_rd(3'd4, d); check("R10 en",   {32'd0, d}, 64'd0);

      // R1: live low word follows the count
      bus_rd(3'd0, lo_snap);
      bus_rd(3'd0, d);
      check("R1 step", {32'd0, d - lo_snap}, {32'd0, 32'(2 * STEP)});

      // R2: held upper word survives a change of the live upper word
      bus_rd(3'd0, lo_snap);
      hi_snap = m_hold;
      idle(80);
      bus_rd(3'd1, d);
      check("R2 held", {32'd0, d}, {32'd0, hi_snap});
      check("R2 stale", {63'd0, d != m_cnt[63:32]}, 64'd1);

      // R8 enable on
      bus_wrt(3'd4, 32'h1);

      // R3: staging the upper word alone arms nothing
      bus_wrt(3'd3, 32'h0);
      idle(3);
      bus_rd(3'd6, d); check("R3 armed", {32'd0, d}, 64'd0);
      check("R3 irq", {63'd0, irq}, 64'd0);

      // R4 / R5: arm in the future, fires once
      arm_at(m_cnt + 64'(10) * 64'(STEP));
      bus_rd(3'd6, d); check("R4 armed", {32'd0, d}, 64'd1);
      idle(15);
      bus_rd(3'd6, d); check("R5 disarmed", {32'd0, d}, 64'd0);
      check("R5 irq", {63'd0, irq}, 64'd1);
      bus_wrt(3'd7, 32'h0);
      idle(20);
      check("R5 oneshot", {63'd0, irq}, 64'd0);

      // R6: negative alarm fires on the edge after arming
      arm_at(64'h8000_0000_0000_0000);
      #2 check("R6 not yet", {63'd0, irq}, 64'd0);
      @(negedge clk); #2;
      check("R6 fired", {63'd0, irq}, 64'd1);
      bus_wrt(3'd7, 32'h0);

      // R7: disarm before reaching
      arm_at(m_cnt + 64'(8) * 64'(STEP));
      bus_wrt(3'd5, 32'h0);
      idle(20);
      check("R7 no pend", {63'd0, irq}, 64'd0);
      bus_rd(3'd6, d); check("R7 armed", {32'd0, d}, 64'd0);

      // R8: pending survives enable toggling, only ack clears it
      bus_wrt(3'd4, 32'h0);
      arm_at(m_cnt - 64'(STEP));
      idle(3);
      check("R8 masked", {63'd0, irq}, 64'd0);
      bus_wrt(3'd4, 32'hFFFF_FFFF);
      #2 check("R8 reappears", {63'd0, irq}, 64'd1);
      bus_rd(3'd4, d); check("R8 en bit", {32'd0, d}, 64'd1);
      bus_wrt(3'd7, 32'h0);
      #2 check("R8 acked", {63'd0, irq}, 64'd0);

      // R9: write-only reads zero, read-only writes ignored
      bus_wrt(3'd0, 32'hDEAD_BEEF);
      bus_wrt(3'd1, 32'hDEAD_BEEF);
      bus_wrt(3'd6, 32'hFFFF_FFFF);
      bus_rd(3'd6, d); check("R9 status", {32'd0, d}, 64'd0);
      bus_rd(3'd0, d);
      bus_rd(3'd2, d); bus_rd(3'd3, d); bus_rd(3'd5, d); bus_rd(3'd7, d);

      // random mix against the model
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         r = $urandom % 10;
         if (r < 4) begin
            bus_rd(3'($urandom % 8), d);
         end else if (r < 6) begin
            int off;
            off = int'($urandom % 60) - 20;
            arm_at(m_cnt + 64'(longint'(off) * longint'(STEP)));
         end else if (r == 6) begin
            arm_at({1'b1, 63'($urandom)});
         end else begin
            bus_wrt(3'($urandom % 8), $urandom);
         end
         if ($urandom % 4 == 0) idle(int'($urandom % 6));
      end

      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule